// File: doc/BRIEF.md
# Interrupt vector ring writer

This block takes interrupt vectors from on-chip clients, one at a time, and stores each one as a 32-byte record in a circular buffer held in system memory. The record is sent out as eight 32-bit word writes on a simple valid/ready memory port. The block owns the producer (write) offset. Software owns the consumer (read) offset and moves it forward through a register once it has parsed records. An interrupt line stays high while interrupts are enabled and records remain unread.

When the ring fills up, the block acts in one of two ways. In overflow-detect mode it keeps writing over the oldest record and sets a sticky flag in the top bit of the readable write-offset register, and software clears that flag through a control bit. In drain mode it withholds `vecReady` until software frees a slot. As an option, after each record the block also stores the write-offset register value, flag included, at a separate writeback address, so software can poll memory instead of the register.

Top module: `ivRingWriter`

## Requirements
- R1: A record occupies eight consecutive words at addresses base + writeOffset + 4*i, with i going from 0 to 7. Word 0 is {vmidFlag, 3'b0, vmid[3:0], ringId[7:0], source[7:0], client[7:0]}. Word 1 is stamp[31:0]. Word 2 is {stampFlag, 15'b0, stamp[47:32]}. Word 3 is {pasidFlag, 15'b0, pasid[15:0]}. Words 4 to 7 are payload bits [31:0], [63:32], [95:64] and [127:96].
- R2: Both offsets count bytes. Once a record's last word is accepted, the write offset advances by 32 modulo the ring size in bytes, which is 4 << size, where size is CTRL bits 12:8. The write offset reads back at register 3, bits PTR_W-1:0.
- R3: While ring-enable (CTRL bit 0) is 0, `vecReady` stays low and no memory write starts.
- R4: With overflow-detect (CTRL bit 2) set and drain (CTRL bit 3) clear, a record accepted while the ring is full is still written, and bit 31 of register 3 becomes 1 and stays 1.
- R5: Writing CTRL with bit 31 = 1 clears the sticky flag. CTRL bit 31 always reads back as 0, and the other CTRL fields take the written value.
- R6: With writeback (CTRL bit 4) set, each record is followed by exactly one word write of the register-3 value to the writeback address (register 4).
- R7: With drain mode set, `vecReady` stays low while the ring is full, meaning (writeOffset+32) mod size equals the read offset. Acceptance resumes once software advances the read offset. In drain mode no overflow flag is set.
- R8: `irq` is high exactly when interrupt-enable (CTRL bit 1) is 1 and the write offset differs from the read offset (register 2).
- R9: A write to register 2 loads the read offset masked to the ring size. A write to register 3 takes effect only while ring-enable is 0: it loads the masked value and clears the flag. Otherwise it is ignored.
- R10: While `memValid` is high and `memReady` is low, `memAddr` and `memData` hold steady. Back-pressure loses no word.
- R11: A size field below 4 is treated as 4, so the smallest ring is 16 words (64 bytes).
- R12: Only one vector is in flight at a time. `vecReady` is low from the acceptance cycle until the record (and its writeback) is done, and `memValid` rises in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select: 0 CTRL, 1 base, 2 read offset, 3 write offset, 4 writeback address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| vecValid | input | 1 | Vector offered |
| vecReady | output | 1 | Vector accepted when high together with vecValid |
| vecClient | input | 8 | Client id |
| vecSource | input | 8 | Source id |
| vecRingId | input | 8 | Ring id |
| vecVmid | input | 4 | Virtual machine id |
| vecVmidFlag | input | 1 | vmid-source flag |
| vecStamp | input | 48 | Timestamp |
| vecStampFlag | input | 1 | Timestamp-source flag |
| vecPasid | input | 16 | Process address space id |
| vecPasidFlag | input | 1 | pasid-source flag |
| vecPayload | input | 128 | Source data |
| memValid | output | 1 | Memory word write request |
| memReady | input | 1 | Memory accepts the word |
| memAddr | output | ADDR_W | Byte address of the word |
| memData | output | 32 | Word data |
| irq | output | 1 | Unread records pending |

## Verification
The hardest state to reach is a record that lands on a full ring. The bench reaches it by parking the read offset and pushing exactly ring-size/32 records into a four-record ring. It does this twice: once with overflow-detect, where it checks the flag both in the register and in the writeback word, and once in drain mode. In drain mode one vector is held pending in a parallel thread while the bench confirms that no write starts, then it frees one slot. Random memory back-pressure is applied across a sweep that wraps the ring more than twice.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int ENTRY_WORDS = 8;
  localparam int ENTRY_BYTES = 32;
  localparam int IDX_W       = $clog2(ENTRY_WORDS);
  localparam int MIN_LOG2_WORDS = 4;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_BASE = 3'd1;
  localparam logic [2:0] REG_RD   = 3'd2;
  localparam logic [2:0] REG_WR   = 3'd3;
  localparam logic [2:0] REG_WB   = 3'd4;

  typedef enum logic [1:0] {ST_IDLE, ST_ENTRY, ST_WB} ivrState_e;

  typedef struct packed {
    logic             takeVec;
    logic             commit;
    logic             selWb;
    logic [IDX_W-1:0] wordIdx;
  } ivrStrobe_t;
endpackage

// File: rtl/ivrCtrl.sv
module ivrCtrl
  import ivr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       vecValid,
  input  logic       memReady,
  input  logic       ringEn,
  input  logic       stallFull,
  input  logic       wbEn,
  output logic       vecReady,
  output logic       memValid,
  output ivrStrobe_t strobe
);
  ivrState_e state;
  logic [IDX_W-1:0] wordIdx;
  logic lastWord;

  assign lastWord = (wordIdx == IDX_W'(ENTRY_WORDS - 1));
  assign vecReady = (state == ST_IDLE) && ringEn && !stallFull;
  assign memValid = (state != ST_IDLE);

  always_comb begin
    strobe.takeVec = vecValid && vecReady;
    strobe.commit  = (state == ST_ENTRY) && memReady && lastWord;
    strobe.selWb   = (state == ST_WB);
    strobe.wordIdx = wordIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      wordIdx <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (strobe.takeVec) begin
          state   <= ST_ENTRY;
          wordIdx <= '0;
        end
        ST_ENTRY: if (memReady) begin
          if (lastWord) state <= wbEn ? ST_WB : ST_IDLE;
          else          wordIdx <= wordIdx + 1'b1;
        end
        ST_WB: if (memReady) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ivrDatapath.sv
module ivrDatapath
  import ivr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 18
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic [7:0]        vecClient,
  input  logic [7:0]        vecSource,
  input  logic [7:0]        vecRingId,
  input  logic [3:0]        vecVmid,
  input  logic              vecVmidFlag,
  input  logic [47:0]       vecStamp,
  input  logic              vecStampFlag,
  input  logic [15:0]       vecPasid,
  input  logic              vecPasidFlag,
  input  logic [127:0]      vecPayload,
  input  ivrStrobe_t        strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              ringEn,
  output logic              intrEn,
  output logic              ovfDetEn,
  output logic              drainEn,
  output logic              wbEn,
  output logic              full,
  output logic              ovf,
  output logic              irq
);
  localparam int MAX_LOG2_WORDS = PTR_W - 2;

  logic [4:0]        sizeField;
  logic [5:0]        effLog2;
  logic [PTR_W-1:0]  ptrMask, wptr, rptr, wptrInc;
  logic [ADDR_W-1:0] base, wbAddr;
  logic [ENTRY_WORDS-1:0][31:0] entryQ, entryD;
  logic [31:0] ctrlWord, wptrWord;

  always_comb begin
    if (sizeField < 5'(MIN_LOG2_WORDS))      effLog2 = 6'(MIN_LOG2_WORDS);
    else if (sizeField > 5'(MAX_LOG2_WORDS)) effLog2 = 6'(MAX_LOG2_WORDS);
    else                                     effLog2 = {1'b0, sizeField};
    ptrMask = PTR_W'((33'd1 << (effLog2 + 6'd2)) - 33'd1);
  end

  assign wptrInc = (wptr + PTR_W'(ENTRY_BYTES)) & ptrMask;
  assign full    = (wptrInc == rptr);
  assign irq     = intrEn && (wptr != rptr);

  // record packing, word order fixed by the consumer's decoder
  always_comb begin
    entryD[0] = {vecVmidFlag, 3'b0, vecVmid, vecRingId, vecSource, vecClient};
    entryD[1] = vecStamp[31:0];
    entryD[2] = {vecStampFlag, 15'b0, vecStamp[47:32]};
    entryD[3] = {vecPasidFlag, 15'b0, vecPasid};
    for (int i = 0; i < 4; i++) entryD[4+i] = vecPayload[32*i +: 32];
  end

  always_ff @(posedge clk) begin
    if (!rstN)              entryQ <= '0;
    else if (strobe.takeVec) entryQ <= entryD;
  end

  assign wptrWord = {ovf, {(31-PTR_W){1'b0}}, wptr};
  assign ctrlWord = {19'b0, sizeField, 3'b0, wbEn, drainEn, ovfDetEn, intrEn, ringEn};

  always_comb begin
    if (strobe.selWb) begin
      memAddr = wbAddr;
      memData = wptrWord;
    end else begin
      memAddr = base + ADDR_W'(wptr) + ADDR_W'({strobe.wordIdx, 2'b00});
      memData = entryQ[strobe.wordIdx];
    end
  end

  always_comb begin
    unique case (regAddr)
      REG_CTRL: regRdData = ctrlWord;
      REG_BASE: regRdData = 32'(base);
      REG_RD:   regRdData = 32'(rptr);
      REG_WR:   regRdData = wptrWord;
      REG_WB:   regRdData = 32'(wbAddr);
      default:  regRdData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {ringEn, intrEn, ovfDetEn, drainEn, wbEn} <= '0;
      sizeField <= '0;
      base      <= '0;
      wbAddr    <= '0;
      rptr      <= '0;
    end else if (regWr) begin
      unique case (regAddr)
        REG_CTRL: begin
          {wbEn, drainEn, ovfDetEn, intrEn, ringEn} <= regWrData[4:0];
          sizeField <= regWrData[12:8];
        end
        REG_BASE: base   <= ADDR_W'(regWrData);
        REG_RD:   rptr   <= regWrData[PTR_W-1:0] & ptrMask;
        REG_WB:   wbAddr <= ADDR_W'(regWrData);
        default: ;
      endcase
    end
  end

  // write offset and sticky flag: later assignments take priority
  always_ff @(posedge clk) begin
    if (!rstN) begin
      wptr <= '0;
      ovf  <= 1'b0;
    end else begin
      if (regWr && regAddr == REG_CTRL && regWrData[31]) ovf <= 1'b0;
      if (regWr && regAddr == REG_WR && !ringEn) begin
        wptr <= regWrData[PTR_W-1:0] & ptrMask;
        ovf  <= 1'b0;
      end
      if (strobe.commit) begin
        wptr <= wptrInc;
        if (ovfDetEn && !drainEn && full) ovf <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/ivRingWriter.sv
module ivRingWriter
  import ivr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 18
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  input  logic              vecValid,
  output logic              vecReady,
  input  logic [7:0]        vecClient,
  input  logic [7:0]        vecSource,
  input  logic [7:0]        vecRingId,
  input  logic [3:0]        vecVmid,
  input  logic              vecVmidFlag,
  input  logic [47:0]       vecStamp,
  input  logic              vecStampFlag,
  input  logic [15:0]       vecPasid,
  input  logic              vecPasidFlag,
  input  logic [127:0]      vecPayload,
  output logic              memValid,
  input  logic              memReady,
  output logic [ADDR_W-1:0] memAddr,
  output logic [31:0]       memData,
  output logic              irq
);
  ivrStrobe_t strobe;
  logic ringEn, intrEn, ovfDetEn, drainEn, wbEn, full, ovf;

  ivrCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .vecValid(vecValid), .memReady(memReady),
    .ringEn(ringEn), .stallFull(drainEn && full), .wbEn(wbEn),
    .vecReady(vecReady), .memValid(memValid), .strobe(strobe)
  );

  ivrDatapath #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) i_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .vecClient(vecClient), .vecSource(vecSource), .vecRingId(vecRingId),
    .vecVmid(vecVmid), .vecVmidFlag(vecVmidFlag), .vecStamp(vecStamp),
    .vecStampFlag(vecStampFlag), .vecPasid(vecPasid), .vecPasidFlag(vecPasidFlag),
    .vecPayload(vecPayload), .strobe(strobe), .memAddr(memAddr), .memData(memData),
    .ringEn(ringEn), .intrEn(intrEn), .ovfDetEn(ovfDetEn), .drainEn(drainEn),
    .wbEn(wbEn), .full(full), .ovf(ovf), .irq(irq)
  );
endmodule

// File: rtl/ivrChecker.sv
module ivrChecker #(
  parameter int ADDR_W = 32
)(
  input logic              clk,
  input logic              rstN,
  input logic              vecValid,
  input logic              vecReady,
  input logic              memValid,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [31:0]       memData,
  input logic              ringEn,
  input logic              drainEn,
  input logic              ovfDetEn,
  input logic              full,
  input logic              ovf
);
  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memReady |=> memValid && $stable(memAddr) && $stable(memData));
  // R3
  ring_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecReady |-> ringEn);
  // R7
  drain_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainEn && full |-> !vecReady);
  // R12
  busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> !vecReady);
  // R12
  start_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && vecReady |=> memValid);
  // R4
  ovf_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ovf) |-> $past(ovfDetEn) && !$past(drainEn));
endmodule

bind ivRingWriter ivrChecker #(.ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rstN(rstN), .vecValid(vecValid), .vecReady(vecReady),
  .memValid(memValid), .memReady(memReady), .memAddr(memAddr), .memData(memData),
  .ringEn(ringEn), .drainEn(drainEn), .ovfDetEn(ovfDetEn), .full(full), .ovf(ovf)
);

// File: tb/test_ivRingWriter.sv
`timescale 1ns/1ps
module test_ivRingWriter;
  logic clk = 0, rstN = 0, regWr = 0;
  logic [2:0] regAddr = 0;
  logic [31:0] regWrData = 0, regRdData;
  logic vecValid = 0, vecReady;
  logic [7:0] vecClient = 0, vecSource = 0, vecRingId = 0;
  logic [3:0] vecVmid = 0;
  logic vecVmidFlag = 0, vecStampFlag = 0, vecPasidFlag = 0;
  logic [47:0] vecStamp = 0;
  logic [15:0] vecPasid = 0;
  logic [127:0] vecPayload = 0;
  logic memValid, memReady = 1;
  logic [31:0] memAddr, memData;
  logic irq;

  int nRun = 0, nFail = 0, memWrites = 0, expW = 0, savedWrites = 0;
  logic [31:0] mem [0:255];
  logic [7:0] lfsr = 8'h5A;
  logic stallOn = 0, finished = 0;
  logic [31:0] rd;

  localparam logic [31:0] C_RING = 1, C_INTR = 2, C_OVF = 4, C_DRAIN = 8, C_WB = 16;
  localparam logic [31:0] C_SIZE5 = 32'd5 << 8;
  localparam int BASE = 32'h100, WBADDR = 32'h200, RING = 128;

  ivRingWriter i_ivRingWriter (.*);

  always #4 clk = ~clk;

  always @(posedge clk) if (memValid && memReady) begin
    mem[memAddr[9:2]] <= memData;
    memWrites <= memWrites + 1;
  end

  always @(negedge clk) begin
    if (stallOn) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      memReady <= lfsr[0];
    end else memReady <= 1'b1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); regAddr = a; regWrData = d; regWr = 1;
    @(negedge clk); regWr = 0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [31:0] d);
    regAddr = a; #1; d = regRdData;
  endtask

  function automatic logic [31:0] expWord(int k, int j);
    logic [7:0] cl = 8'(k*7+1), sr = 8'(k*3+2), rg = 8'(k);
    logic [3:0] vm = 4'(k);
    logic [47:0] ts = {16'(k*5), 32'(k*1000+17)};
    logic [15:0] pa = 16'(k*257);
    case (j)
      0: return {k[0], 3'b0, vm, rg, sr, cl};
      1: return ts[31:0];
      2: return {k[1], 15'b0, ts[47:32]};
      3: return {k[2], 15'b0, pa};
      default: return 32'hA000_0000 + 32'(k*16 + j - 4);
    endcase
  endfunction

  task automatic sendVec(input int k);
    logic r;
    logic [47:0] ts = {16'(k*5), 32'(k*1000+17)};
    @(negedge clk);
    vecClient = 8'(k*7+1); vecSource = 8'(k*3+2); vecRingId = 8'(k); vecVmid = 4'(k);
    vecVmidFlag = k[0]; vecStamp = ts; vecStampFlag = k[1];
    vecPasid = 16'(k*257); vecPasidFlag = k[2];
    for (int j = 0; j < 4; j++) vecPayload[32*j +: 32] = 32'hA000_0000 + 32'(k*16 + j);
    vecValid = 1;
    while (1) begin
      r = vecReady;
      @(posedge clk);
      if (r) break;
      @(negedge clk);
    end
    @(negedge clk); vecValid = 0;
    chk("R12 ready low while busy", {31'b0, vecReady}, 0);
    chk("R12 memValid after accept", {31'b0, memValid}, 1);
  endtask

  task automatic waitDone();
    int n = 0;
    while (!vecReady && n < 60) begin @(negedge clk); n++; end
  endtask

  task automatic checkEntry(input int k, input int off);
    for (int j = 0; j < 8; j++)
      chk("R1 R10 word", mem[8'((BASE + off) / 4 + j)], expWord(k, j));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rdReg(0, rd); chk("R5 reset CTRL", rd, 0);
    rdReg(3, rd); chk("R2 reset WPTR", rd, 0);
    chk("R8 reset irq", {31'b0, irq}, 0);
    chk("R3 reset ready", {31'b0, vecReady}, 0);

    // R3: vector offered to a disabled ring
    vecValid = 1;
    repeat (10) begin
      @(negedge clk);
      chk("R3 disabled ready", {31'b0, vecReady}, 0);
    end
    vecValid = 0;
    chk("R3 no writes", memWrites, 0);

    wrReg(1, BASE);
    wrReg(0, C_RING | C_INTR | C_OVF | C_SIZE5);
    rdReg(0, rd); chk("R5 CTRL readback", rd, C_RING | C_INTR | C_OVF | C_SIZE5);

    // sweep with wrap and random back-pressure (R1, R2, R8, R10)
    for (int k = 0; k < 10; k++) begin
      stallOn = (k % 3 != 0);
      savedWrites = memWrites;
      sendVec(k);
      waitDone();
      stallOn = 0;
      checkEntry(k, expW);
      chk("R12 eight writes", memWrites - savedWrites, 8);
      expW = (expW + 32) % RING;
      rdReg(3, rd); chk("R2 WPTR advance", rd, expW);
      chk("R8 irq pending", {31'b0, irq}, 1);
      wrReg(2, expW);
      chk("R8 irq cleared", {31'b0, irq}, 0);
    end

    // R9: WPTR write ignored while enabled, RPTR masked
    wrReg(3, 32'h40);
    rdReg(3, rd); chk("R9 WPTR write ignored", rd, expW);
    wrReg(2, 32'h1FF5);
    rdReg(2, rd); chk("R9 RPTR masked", rd, 32'h1FF5 & (RING - 1));
    wrReg(2, expW);

    // R4 and R6: overflow with writeback
    wrReg(4, WBADDR);
    wrReg(0, C_RING | C_INTR | C_OVF | C_WB | C_SIZE5);
    for (int k = 10; k < 13; k++) begin
      savedWrites = memWrites;
      sendVec(k); waitDone();
      expW = (expW + 32) % RING;
      chk("R6 writeback word", mem[WBADDR / 4], expW);
      chk("R6 nine writes", memWrites - savedWrites, 9);
    end
    sendVec(13); waitDone();
    expW = (expW + 32) % RING;
    checkEntry(13, (expW + RING - 32) % RING);
    rdReg(3, rd); chk("R4 overflow flag set", rd, 32'h8000_0000 | expW);
    chk("R6 writeback carries flag", mem[WBADDR / 4], 32'h8000_0000 | expW);
    repeat (3) @(negedge clk);
    rdReg(3, rd); chk("R4 flag sticky", rd, 32'h8000_0000 | expW);

    // R5: clear
    wrReg(0, 32'h8000_0000 | C_RING | C_INTR | C_OVF | C_SIZE5);
    rdReg(3, rd); chk("R5 flag cleared", rd, expW);
    rdReg(0, rd); chk("R5 CTRL bit31 reads 0", rd, C_RING | C_INTR | C_OVF | C_SIZE5);

    // R7: drain mode
    wrReg(0, C_RING | C_INTR | C_DRAIN | C_SIZE5);
    for (int k = 14; k < 17; k++) begin
      sendVec(k); waitDone();
      expW = (expW + 32) % RING;
    end
    savedWrites = memWrites;
    fork
      sendVec(20);
      begin
        repeat (12) @(negedge clk);
        chk("R7 stalled when full", {31'b0, vecReady}, 0);
        chk("R7 no write when full", memWrites - savedWrites, 0);
        wrReg(2, (expW + 64) % RING);
      end
    join
    waitDone();
    checkEntry(20, expW);
    expW = (expW + 32) % RING;
    rdReg(3, rd); chk("R7 resumed, no flag", rd, expW);

    // R9: pointer reset while disabled
    wrReg(0, 0);
    wrReg(2, 0);
    wrReg(3, 0);
    rdReg(2, rd); chk("R9 RPTR zeroed", rd, 0);
    rdReg(3, rd); chk("R9 WPTR zeroed", rd, 0);
    chk("R8 irq off", {31'b0, irq}, 0);

    // R11: size field 0 clamps to 64 bytes
    wrReg(0, C_RING);
    sendVec(30); waitDone();
    rdReg(3, rd); chk("R11 first step", rd, 32);
    sendVec(31); waitDone();
    rdReg(3, rd); chk("R11 wrap at 64", rd, 0);
    checkEntry(31, 32);

    summary();
  end
endmodule